// File: doc/BRIEF.md
# Lockable system status register bank

This block is a small memory-mapped bank of board status and control registers. It sits on a plain 32-bit bus with byte offsets from 0x00 to 0xFF. It holds a constant identity word, a key register that unlocks the reset-control register, two sets of flag bits that are set and cleared through separate offsets, a display control word, a view of two card-status inputs, and a free-running counter that advances at 24 MHz.

A board-type parameter, which also appears in the identity word, chooses the variant. It decides which display bits software can change, which reset-control bit requests a system reset, where the card write-protect bit sits, and whether the reset and display registers exist at all. A qualifying reset write produces a one-cycle request pulse. On the oldest variant, the low two display bits drive a 2-bit mux select output.

Reads are combinational on the address. Writes take effect at the clock edge. The ordinary reset `rst_n` clears every register except the non-volatile flags, which only the power-on reset `por_n` clears.

Top module: `sysstat_regs`

## Requirements
- R1: Offset 0x00 reads a constant word with the 12-bit board type in bits [27:16] and zero elsewhere. The board types are 0x100 and 0x140 (older), 0x178 and 0x182 (middle), and 0x190 (later, no reset or display register).
- R2: A write to 0x20 with data[15:0] equal to 0xA05F stores 0xA05F. Any other write stores {0, data[14:0]}. Offset 0x20 reads the stored 16 bits zero-extended, and reset clears them.
- R3: Offset 0x30 reads the flags. A write to 0x30 ORs the data into the flags, and a write to 0x34 clears the flag bits that are set in the data. `rst_n` clears the flags.
- R4: The non-volatile flags read at 0x38. A write to 0x38 sets bits and a write to 0x3C clears bits. `rst_n` leaves them unchanged and only `por_n` clears them.
- R5: A write to 0x40 is stored, and reads back at 0x40, only while the stored key equals 0xA05F. On board type 0x190 the offset reads zero and ignores writes.
- R6: A stored 0x40 write with the request bit set raises `rst_req` for exactly one cycle, in the cycle after the write. The request bit is bit 8 on older boards and bit 2 on middle boards. A qualifying write in the cycle right after a pulse does not extend the pulse.
- R7: The display word at 0x50 resets to 0x1F00. On board type 0x190 it reads zero and ignores writes.
- R8: On older boards a display write leaves bits [13:8] unchanged and writes every other bit. `disp_mux` shows display bits [1:0] on board type 0x100 and is 0 on all other board types.
- R9: On middle boards a display write leaves bit 7 unchanged and writes every other bit.
- R10: Offset 0x48 reads `card_in` in bit 0. It reads `card_wp` in bit 2 on older boards and in bit 1 on later boards. All other bits read zero.
- R11: Offset 0x5C reads a counter that adds TICK_HZ/CLK_HZ per clock on average. With the default 48 MHz clock it advances by one every second cycle.
- R12: Any other offset, including an unaligned one, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, also clears the non-volatile flags |
| sel | input | 1 | Bus access in this cycle |
| wr | input | 1 | Access is a write |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| card_in | input | 1 | Card-inserted status |
| card_wp | input | 1 | Card write-protect status |
| rst_req | output | 1 | One-cycle system reset request |
| disp_mux | output | 2 | Display format mux select |

## Verification
A write changes register state at the clock edge where it is sampled. Because `rdata` depends combinationally on `addr`, the new value is visible at the next falling edge, with no added read latency. `rst_req` is registered and becomes high at the same edge as the write it follows, so it is compared in that same half-cycle.

The bench drives the bus just after each falling edge and steps its own behavioural model at each rising edge. At every falling edge it compares `rdata`, `rst_req` and `disp_mux` of three board variants against that model. The counter is checked as a difference between two reads taken ten edges apart.

// File: rtl/sysstat_regs.sv
module sysstat_regs #(
  parameter logic [11:0] BOARD_ID = 12'h100,
  parameter int CLK_HZ  = 48_000_000,
  parameter int TICK_HZ = 24_000_000,
  parameter int CNT_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        card_in,
  input  logic        card_wp,
  output logic        rst_req,
  output logic [1:0]  disp_mux
);
  localparam logic [15:0] KEY = 16'hA05F;
  localparam bit IS_OLD  = (BOARD_ID == 12'h100) || (BOARD_ID == 12'h140);
  localparam bit IS_MID  = (BOARD_ID == 12'h178) || (BOARD_ID == 12'h182);
  localparam bit IS_NONE = !(IS_OLD || IS_MID);
  localparam bit HAS_MUX = (BOARD_ID == 12'h100);
  localparam int REQ_BIT = IS_OLD ? 8 : 2;
  localparam logic [31:0] DISP_KEEP = IS_OLD ? 32'h0000_3F00 :
                                      IS_MID ? 32'h0000_0080 : 32'hFFFF_FFFF;
  localparam logic [31:0] DISP_INIT = IS_NONE ? 32'h0 : 32'h0000_1F00;
  localparam int ACC_W = $clog2(CLK_HZ) + 2;

  logic [15:0]      lock_q;
  logic [31:0]      flags_q, nv_q, rctl_q, disp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic             we, key_ok, rctl_wr;

  assign we      = sel && wr;
  assign key_ok  = (lock_q == KEY);
  assign rctl_wr = !IS_NONE && we && (addr == 8'h40) && key_ok;
  assign acc_sum = acc_q + ACC_W'(TICK_HZ);
  assign disp_mux = HAS_MUX ? disp_q[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      flags_q <= '0;
      rctl_q  <= '0;
      disp_q  <= DISP_INIT;
      rst_req <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      if (we && addr == 8'h20)
        lock_q <= (wdata[15:0] == KEY) ? KEY : {1'b0, wdata[14:0]};
      if (we && addr == 8'h30) flags_q <= flags_q | wdata;
      if (we && addr == 8'h34) flags_q <= flags_q & ~wdata;
      if (rctl_wr) rctl_q <= wdata;
      rst_req <= rctl_wr && wdata[REQ_BIT] && !rst_req;
      if (we && addr == 8'h50)
        disp_q <= (disp_q & DISP_KEEP) | (wdata & ~DISP_KEEP);
      if (acc_sum >= ACC_W'(CLK_HZ)) begin
        acc_q <= acc_sum - ACC_W'(CLK_HZ);
        cnt_q <= cnt_q + 1'b1;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    nv_q <= '0;
    else if (we && addr == 8'h38)  nv_q <= nv_q | wdata;
    else if (we && addr == 8'h3C)  nv_q <= nv_q & ~wdata;
  end

  always_comb begin
    case (addr)
      8'h00: rdata = {4'h0, BOARD_ID, 16'h0000};
      8'h20: rdata = {16'h0000, lock_q};
      8'h30: rdata = flags_q;
      8'h38: rdata = nv_q;
      8'h40: rdata = IS_NONE ? 32'h0 : rctl_q;
      8'h48: rdata = {29'h0, IS_OLD ? {card_wp, 1'b0} : {1'b0, card_wp}, card_in};
      8'h50: rdata = disp_q;
      8'h5C: rdata = 32'(cnt_q);
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/sysstat_regs_chk.sv
module sysstat_regs_chk #(
  parameter logic [11:0] BOARD_ID = 12'h100,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             sel,
  input logic             wr,
  input logic [7:0]       addr,
  input logic [31:0]      wdata,
  input logic             rst_req,
  input logic [15:0]      lock_q,
  input logic [31:0]      flags_q,
  input logic [31:0]      nv_q,
  input logic [31:0]      disp_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam bit IS_OLD = (BOARD_ID == 12'h100) || (BOARD_ID == 12'h140);
  logic we;
  assign we = sel && wr;

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_req_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(we && addr == 8'h40 && lock_q == 16'hA05F));

  assert_key_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[15] |-> (lock_q == 16'hA05F));

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h30) |=> ((flags_q & $past(wdata)) == $past(wdata)));

  assert_nv_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
    (we && addr == 8'h3C) |=> ((nv_q & $past(wdata)) == 32'h0));

  assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  generate
    if (IS_OLD) begin : g_old
      assert_disp_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(disp_q[13:8]));
    end
  endgenerate
endmodule

bind sysstat_regs sysstat_regs_chk #(.BOARD_ID(BOARD_ID), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .sel(sel), .wr(wr), .addr(addr),
  .wdata(wdata), .rst_req(rst_req), .lock_q(lock_q), .flags_q(flags_q),
  .nv_q(nv_q), .disp_q(disp_q), .cnt_q(cnt_q)
);

// File: tb/sysstat_regs_test.sv
module sysstat_regs_test;
  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, card_in = 1'b0, card_wp = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rd [3];
  logic        rq [3];
  logic [1:0]  mx [3];
  int checks = 0, failures = 0;
  bit done = 1'b0;
  localparam logic [11:0] IDS [3] = '{12'h100, 12'h182, 12'h190};

  always #4 clk = ~clk;

  sysstat_regs #(.BOARD_ID(12'h100)) uut (.clk(clk), .rst_n(rst_n), .por_n(por_n),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rd[0]), .card_in(card_in),
    .card_wp(card_wp), .rst_req(rq[0]), .disp_mux(mx[0]));
  sysstat_regs #(.BOARD_ID(12'h182)) uut_mid (.clk(clk), .rst_n(rst_n), .por_n(por_n),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rd[1]), .card_in(card_in),
    .card_wp(card_wp), .rst_req(rq[1]), .disp_mux(mx[1]));
  sysstat_regs #(.BOARD_ID(12'h190)) uut_late (.clk(clk), .rst_n(rst_n), .por_n(por_n),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rd[2]), .card_in(card_in),
    .card_wp(card_wp), .rst_req(rq[2]), .disp_mux(mx[2]));

  function automatic int kind(logic [11:0] id);
    if (id == 12'h100 || id == 12'h140) return 0;
    if (id == 12'h178 || id == 12'h182) return 1;
    return 2;
  endfunction

  logic [15:0] m_lock;
  logic [31:0] m_flags, m_nv;
  logic [31:0] m_rc [3];
  logic [31:0] m_disp [3];
  logic        m_req [3];

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) m_nv = 32'h0;
    if (!rst_n) begin
      m_lock = 16'h0;
      m_flags = 32'h0;
      for (int b = 0; b < 3; b++) begin
        m_rc[b] = 32'h0;
        m_disp[b] = (kind(IDS[b]) == 2) ? 32'h0 : 32'h1F00;
        m_req[b] = 1'b0;
      end
    end else begin
      for (int b = 0; b < 3; b++) begin
        int k;
        bit hit;
        k = kind(IDS[b]);
        hit = sel && wr && addr == 8'h40 && k != 2 && m_lock == 16'hA05F;
        if (hit) m_rc[b] = wdata;
        m_req[b] = hit && wdata[(k == 0) ? 8 : 2] && !m_req[b];
        if (sel && wr && addr == 8'h50) begin
          if (k == 0) m_disp[b] = (m_disp[b] & 32'h3F00) | (wdata & ~32'h3F00);
          else if (k == 1) m_disp[b] = (m_disp[b] & 32'h80) | (wdata & ~32'h80);
        end
      end
      if (sel && wr) begin
        if (addr == 8'h20) m_lock = (wdata[15:0] == 16'hA05F) ? 16'hA05F : {1'b0, wdata[14:0]};
        if (addr == 8'h30) m_flags = m_flags | wdata;
        if (addr == 8'h34) m_flags = m_flags & ~wdata;
        if (addr == 8'h38) m_nv = m_nv | wdata;
        if (addr == 8'h3C) m_nv = m_nv & ~wdata;
      end
    end
  end

  function automatic logic [31:0] exp_read(int b, logic [7:0] a);
    int k;
    k = kind(IDS[b]);
    case (a)
      8'h00: return {4'h0, IDS[b], 16'h0};
      8'h20: return {16'h0, m_lock};
      8'h30: return m_flags;
      8'h38: return m_nv;
      8'h40: return (k == 2) ? 32'h0 : m_rc[b];
      8'h48: return {29'h0, (k == 0) ? {card_wp, 1'b0} : {1'b0, card_wp}, card_in};
      8'h50: return m_disp[b];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int b, logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h20: return "R2";
      8'h30: return "R3";
      8'h38: return "R4";
      8'h40: return "R5";
      8'h48: return "R10";
      8'h50: return (kind(IDS[b]) == 0) ? "R8" : (kind(IDS[b]) == 1) ? "R9" : "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(bit ok, string req, int b, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s board=%0d t=%0t actual=%h expected=%h", req, b, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && por_n && !done) begin
      for (int b = 0; b < 3; b++) begin
        if (addr != 8'h5C)
          check(rd[b] === exp_read(b, addr), tag_of(b, addr), b, rd[b], exp_read(b, addr));
        check(rq[b] === m_req[b], "R6", b, {31'h0, rq[b]}, {31'h0, m_req[b]});
        check(mx[b] === ((b == 0) ? m_disp[b][1:0] : 2'b00), "R8", b,
              {30'h0, mx[b]}, {30'h0, (b == 0) ? m_disp[b][1:0] : 2'b00});
      end
    end
  end

  task automatic bus(bit s, bit w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    #1;
    sel = s; wr = w; addr = a; wdata = d;
  endtask

  task automatic sweep();
    for (int a = 0; a < 8'h64; a += 4) bus(1'b1, 1'b0, 8'(a), 32'h0);
    bus(1'b1, 1'b0, 8'hFC, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0 [3];
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    // reset state: R1, R7, R12
    sweep();
    // R3 flags
    bus(1'b1, 1'b1, 8'h30, 32'h0000_F0F0);
    bus(1'b1, 1'b1, 8'h34, 32'h0000_00F0);
    bus(1'b1, 1'b0, 8'h30, 32'h0);
    // R4 nv flags
    bus(1'b1, 1'b1, 8'h38, 32'h1234_0005);
    bus(1'b1, 1'b1, 8'h3C, 32'h0000_0004);
    bus(1'b1, 1'b0, 8'h38, 32'h0);
    // R12 ignored writes
    bus(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF);
    bus(1'b1, 1'b1, 8'h31, 32'hFFFF_FFFF);
    bus(1'b1, 1'b1, 8'hFC, 32'hFFFF_FFFF);
    sweep();
    // R5 locked, R2 non-key value
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0104);
    bus(1'b1, 1'b0, 8'h40, 32'h0);
    bus(1'b1, 1'b1, 8'h20, 32'h0000_FFFF);
    bus(1'b1, 1'b0, 8'h20, 32'h0);
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0104);
    bus(1'b1, 1'b0, 8'h40, 32'h0);
    // R2 key, R5 + R6 request bits
    bus(1'b1, 1'b1, 8'h20, 32'hFFFF_A05F);
    bus(1'b1, 1'b0, 8'h20, 32'h0);
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0100);
    bus(1'b1, 1'b0, 8'h40, 32'h0);
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0004);
    bus(1'b1, 1'b0, 8'h40, 32'h0);
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0104);
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0104);
    bus(1'b1, 1'b1, 8'h40, 32'h0000_0104);
    bus(1'b0, 1'b0, 8'h40, 32'h0);
    bus(1'b0, 1'b0, 8'h40, 32'h0);
    // R7, R8, R9 display masks
    bus(1'b1, 1'b1, 8'h50, 32'hFFFF_FFFF);
    bus(1'b1, 1'b0, 8'h50, 32'h0);
    bus(1'b1, 1'b1, 8'h50, 32'h0000_0002);
    bus(1'b1, 1'b0, 8'h50, 32'h0);
    bus(1'b1, 1'b1, 8'h50, 32'h0000_0081);
    bus(1'b1, 1'b0, 8'h50, 32'h0);
    // R10 card status
    for (int v = 0; v < 4; v++) begin
      bus(1'b1, 1'b0, 8'h48, 32'h0);
      card_in = v[0];
      card_wp = v[1];
      bus(1'b1, 1'b0, 8'h48, 32'h0);
    end
    // R11 counter: ten rising edges give five ticks
    bus(1'b1, 1'b0, 8'h5C, 32'h0);
    @(negedge clk);
    #2;
    for (int b = 0; b < 3; b++) c0[b] = rd[b];
    repeat (10) @(negedge clk);
    #2;
    for (int b = 0; b < 3; b++)
      check(rd[b] - c0[b] == 32'd5, "R11", b, rd[b] - c0[b], 32'd5);
    // R3/R4 ordinary reset keeps nv flags
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sweep();
    // R4 power-on reset clears nv flags
    @(negedge clk);
    rst_n = 1'b0;
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    bus(1'b1, 1'b0, 8'h38, 32'h0);
    bus(1'b1, 1'b0, 8'h20, 32'h0);
    bus(1'b0, 1'b0, 8'h00, 32'h0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule